// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block watches a bundle of probe signals and records them, one sample per rising clock edge, into an internal sample memory. What gets recorded is chosen by a capture mode and a trigger pulse supplied by a separate trigger unit. In single-shot mode a signed holdoff value places the recorded window relative to the first trigger after arming. Negative values keep pre-trigger history in a circular buffer, and positive values delay the start of recording. Incremental mode stores only the cycles on which the trigger is high. Immediate mode records straight after arming, whatever the trigger does.

Software sets the mode and the holdoff through a small word-addressed register interface, issues an arm command and polls a status word. Once the capture is complete, a separate read port returns the stored samples in time order, oldest first. Each sample comes with a flag that tells whether that window position was ever filled.

Top module: `lacap_top`

## Requirements
- R1: After reset the state code is IDLE (0), the done flag is 0, the mode register reads 0 and the holdoff register reads -DEPTH/2. Mode codes are: 0 single-shot, 1 incremental, 2 immediate, and 3 behaves as single-shot. The register addresses are: 0 mode in bits [1:0], 1 holdoff (signed, sign-extended on read), 2 control (writing bit 0 = 1 arms the block), 3 status. The status word carries the state in [2:0], done in [3] and gaps in [4]. The state codes are IDLE 0, ARMED 1, HOLD 2, CAPTURE 3 and DONE 4.
- R2: An arm command clears the done flag and all position-valid flags. It enters ARMED (single-shot or incremental) or CAPTURE (immediate), and it restarts the block from any state.
- R3: In single-shot mode with holdoff H <= 0, the sample taken on the trigger edge lands at window position min(-H, DEPTH-1). The window holds DEPTH consecutive cycles.
- R4: In single-shot mode with H > 0, window position 0 holds the sample taken H cycles after the trigger edge. The state reads HOLD while the block waits.
- R5: In incremental mode, a sample is stored only on edges where the trigger is high. The capture completes after DEPTH such edges.
- R6: In immediate mode, samples are stored on the DEPTH edges that follow the arm edge.
- R7: When a capture completes, the state becomes DONE and the done flag is set. Later trigger pulses change neither the state nor the stored samples.
- R8: The read port returns window position rd_idx on rd_data and rd_ok one clock after rd_idx is presented. Position 0 is the oldest sample.
- R9: If a trigger arrives before enough pre-trigger cycles have passed, the capture is still accepted. The positions that were never written read with rd_ok = 0, and status bit 4 is set.
- R10: Writes to the mode and holdoff registers take effect only in IDLE or DONE. Outside those states they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe | input | PROBE_W | Probe bundle sampled every edge |
| trig | input | 1 | Trigger condition from the trigger unit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| rd_idx | input | $clog2(DEPTH) | Window position to read |
| rd_data | output | PROBE_W | Sample at the requested position, one cycle later |
| rd_ok | output | 1 | The requested position was written in this capture |

## Verification
The bench builds the block with DEPTH = 8 and PROBE_W = 16. It drives the probe bundle as a free-running cycle count, so every stored sample identifies the exact cycle it came from. The short depth puts the extreme holdoffs within a few dozen cycles: the centred default, zero, a positive delay, and a value below -(DEPTH-1) that must clamp to the last position. It also makes it cheap to fire a trigger on the first edge after arming, so that half the window is left unwritten and the invalid flags and the gaps bit can be observed. The 16-bit count cannot wrap within the run, so expected samples follow directly from the cycle numbers.

// File: rtl/lacap_pkg.sv
package lacap_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARMED = 3'd1,
      ST_HOLD  = 3'd2,
      ST_CAPT  = 3'd3,
      ST_DONE  = 3'd4
   } lacap_state_e;

   typedef enum logic [1:0] {
      MD_SINGLE = 2'd0,
      MD_INCR   = 2'd1,
      MD_IMM    = 2'd2,
      MD_RSVD   = 2'd3
   } lacap_mode_e;

   localparam logic [1:0] RA_MODE = 2'd0;
   localparam logic [1:0] RA_HOLD = 2'd1;
   localparam logic [1:0] RA_CTRL = 2'd2;
   localparam logic [1:0] RA_STAT = 2'd3;

endpackage

// File: rtl/lacap_regs.sv
module lacap_regs
   import lacap_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int HOLD_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_we,
   input  logic [1:0]               reg_addr,
   input  logic [31:0]              reg_wdata,
   input  lacap_state_e             state,
   input  logic                     done,
   input  logic                     gaps,
   output lacap_mode_e              mode,
   output logic signed [HOLD_W-1:0] holdoff,
   output logic                     arm,
   output logic [31:0]              reg_rdata
);

   localparam logic signed [HOLD_W-1:0] HOLD_RST = HOLD_W'(-(DEPTH / 2));

   logic cfg_open;

   assign cfg_open = (state == ST_IDLE) || (state == ST_DONE);
   assign arm      = reg_we && (reg_addr == RA_CTRL) && reg_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= MD_SINGLE;
         holdoff <= HOLD_RST;
      end else if (reg_we && cfg_open) begin
         if (reg_addr == RA_MODE) mode <= lacap_mode_e'(reg_wdata[1:0]);
         if (reg_addr == RA_HOLD) holdoff <= $signed(reg_wdata[HOLD_W-1:0]);
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_MODE: reg_rdata = {30'd0, mode};
         RA_HOLD: reg_rdata = 32'(holdoff);
         RA_CTRL: reg_rdata = '0;
         RA_STAT: reg_rdata = {27'd0, gaps, done, state};
         default: reg_rdata = '0;
      endcase
   end

   a_r10_mode_locked : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_MODE && !cfg_open) |=> $stable(mode));
   a_r10_hold_locked : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_HOLD && !cfg_open) |=> $stable(holdoff));

endmodule

// File: rtl/lacap_seq.sv
module lacap_seq
   import lacap_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int HOLD_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     arm,
   input  lacap_mode_e              mode,
   input  logic signed [HOLD_W-1:0] holdoff,
   input  logic                     trig,
   output lacap_state_e             state,
   output logic                     done,
   output logic                     wr_en,
   output logic [$clog2(DEPTH)-1:0] wr_slot,
   output logic [$clog2(DEPTH)-1:0] start_slot,
   output logic                     clr_valid
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;
   localparam logic signed [HOLD_W-1:0] NEG_LIM = HOLD_W'(-(DEPTH - 1));
   localparam logic signed [HOLD_W-1:0] ZERO_H  = '0;
   localparam logic signed [HOLD_W-1:0] ONE_H   = HOLD_W'(1);
   localparam logic signed [HOLD_W-1:0] TWO_H   = HOLD_W'(2);
   localparam logic [CW-1:0] FULL  = CW'(DEPTH);
   localparam logic [CW-1:0] LAST  = CW'(DEPTH - 1);
   localparam logic [CW-1:0] ONE_C = CW'(1);

   logic [AW-1:0]            wptr;
   logic [CW-1:0]            rem;
   logic [HOLD_W-1:0]        hcnt;
   logic [AW-1:0]            start_q;
   logic signed [HOLD_W-1:0] neg_h;
   logic [CW-1:0]            pre;
   logic [CW-1:0]            post_left;
   logic                     single;

   assign single     = (mode != MD_INCR) && (mode != MD_IMM);
   assign neg_h      = -holdoff;
   assign wr_slot    = wptr;
   assign start_slot = start_q;
   assign clr_valid  = arm;

   // pre-trigger depth, clamped to the last window position
   always_comb begin
      if (holdoff <= NEG_LIM)    pre = LAST;
      else if (holdoff < ZERO_H) pre = neg_h[CW-1:0];
      else                       pre = '0;
   end
   assign post_left = LAST - pre;

   always_comb begin
      wr_en = 1'b0;
      unique case (state)
         ST_ARMED: wr_en = (mode == MD_INCR) ? trig : 1'b1;
         ST_CAPT:  wr_en = 1'b1;
         default:  wr_en = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         done    <= 1'b0;
         wptr    <= '0;
         rem     <= '0;
         hcnt    <= '0;
         start_q <= '0;
      end else if (arm) begin
         state   <= (mode == MD_IMM) ? ST_CAPT : ST_ARMED;
         done    <= 1'b0;
         wptr    <= '0;
         rem     <= FULL;
         hcnt    <= '0;
         start_q <= '0;
      end else begin
         if (wr_en) wptr <= wptr + AW'(1);
         unique case (state)
            ST_ARMED: begin
               if (trig) begin
                  if (!single) begin
                     rem <= rem - ONE_C;
                     if (rem == ONE_C) begin
                        state <= ST_DONE;
                        done  <= 1'b1;
                     end
                  end else if (holdoff > ZERO_H) begin
                     if (holdoff == ONE_H) begin
                        state   <= ST_CAPT;
                        start_q <= wptr + AW'(1);
                        rem     <= FULL;
                     end else begin
                        state <= ST_HOLD;
                        hcnt  <= holdoff - TWO_H;
                     end
                  end else begin
                     start_q <= wptr - pre[AW-1:0];
                     if (post_left == '0) begin
                        state <= ST_DONE;
                        done  <= 1'b1;
                     end else begin
                        state <= ST_CAPT;
                        rem   <= post_left;
                     end
                  end
               end
            end
            ST_HOLD: begin
               if (hcnt == '0) begin
                  state   <= ST_CAPT;
                  start_q <= wptr;
                  rem     <= FULL;
               end else begin
                  hcnt <= hcnt - HOLD_W'(1);
               end
            end
            ST_CAPT: begin
               rem <= rem - ONE_C;
               if (rem == ONE_C) begin
                  state <= ST_DONE;
                  done  <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   a_r2_arm_enters : assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (!done && (state == ST_ARMED || state == ST_CAPT)));
   a_r4_hold_no_write : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && !arm) |=> $stable(wptr));
   a_r5_incr_skip : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ARMED && mode == MD_INCR && !trig && !arm) |=> $stable(wptr));
   a_r6_rem_bound : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CAPT) |-> (rem != '0 && rem <= FULL));
   a_r7_done_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE && !arm) |=> (state == ST_DONE && done && $stable(start_q)));
   a_r7_done_flag : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (state == ST_DONE));

endmodule

// File: rtl/lacap_store.sv
module lacap_store #(
   parameter int DEPTH   = 64,
   parameter int PROBE_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_slot,
   input  logic [PROBE_W-1:0]       wr_data,
   input  logic                     clr_valid,
   input  logic [$clog2(DEPTH)-1:0] start_slot,
   input  logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic [PROBE_W-1:0]       rd_data,
   output logic                     rd_ok,
   output logic                     all_valid
);

   localparam int AW = $clog2(DEPTH);

   logic [PROBE_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]   valid;
   logic [AW-1:0]      rd_slot;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_slot] <= wr_data;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic v;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               v <= 1'b0;
         else if (clr_valid)                       v <= 1'b0;
         else if (wr_en && wr_slot == AW'(g))      v <= 1'b1;
      end
      assign valid[g] = v;
   end

   assign rd_slot   = start_slot + rd_idx;
   assign all_valid = &valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_ok   <= 1'b0;
      end else begin
         rd_data <= mem[rd_slot];
         rd_ok   <= valid[rd_slot];
      end
   end

   a_r9_clear_all : assert property (@(posedge clk) disable iff (!rst_n)
      clr_valid |=> (valid == '0));
   a_r9_mark_written : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr_valid) |=> valid[$past(wr_slot)]);

endmodule

// File: rtl/lacap_top.sv
module lacap_top
   import lacap_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int PROBE_W = 32,
   parameter int HOLD_W  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [PROBE_W-1:0]       probe,
   input  logic                     trig,
   input  logic                     reg_we,
   input  logic [1:0]               reg_addr,
   input  logic [31:0]              reg_wdata,
   output logic [31:0]              reg_rdata,
   input  logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic [PROBE_W-1:0]       rd_data,
   output logic                     rd_ok
);

   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("lacap_top: DEPTH must be a power of two, at least 4");
   end
   if (PROBE_W < 1 || PROBE_W > 256) begin : g_bad_probe
      $error("lacap_top: PROBE_W must lie in 1..256");
   end
   if (HOLD_W < AW + 2 || HOLD_W > 32) begin : g_bad_hold
      $error("lacap_top: HOLD_W must lie in clog2(DEPTH)+2..32");
   end

   lacap_state_e             state;
   lacap_mode_e              mode;
   logic signed [HOLD_W-1:0] holdoff;
   logic                     arm;
   logic                     done;
   logic                     gaps;
   logic                     wr_en;
   logic [AW-1:0]            wr_slot;
   logic [AW-1:0]            start_slot;
   logic                     clr_valid;
   logic                     all_valid;

   assign gaps = done && !all_valid;

   lacap_regs #(.DEPTH(DEPTH), .HOLD_W(HOLD_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .state     (state),
      .done      (done),
      .gaps      (gaps),
      .mode      (mode),
      .holdoff   (holdoff),
      .arm       (arm),
      .reg_rdata (reg_rdata)
   );

   lacap_seq #(.DEPTH(DEPTH), .HOLD_W(HOLD_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .mode       (mode),
      .holdoff    (holdoff),
      .trig       (trig),
      .state      (state),
      .done       (done),
      .wr_en      (wr_en),
      .wr_slot    (wr_slot),
      .start_slot (start_slot),
      .clr_valid  (clr_valid)
   );

   lacap_store #(.DEPTH(DEPTH), .PROBE_W(PROBE_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_slot    (wr_slot),
      .wr_data    (probe),
      .clr_valid  (clr_valid),
      .start_slot (start_slot),
      .rd_idx     (rd_idx),
      .rd_data    (rd_data),
      .rd_ok      (rd_ok),
      .all_valid  (all_valid)
   );

   a_r9_gaps_only_done : assert property (@(posedge clk) disable iff (!rst_n)
      gaps |-> (state == ST_DONE));

endmodule

// File: tb/sim_lacap_top.sv
`timescale 1ns/1ps
module sim_lacap_top;

   localparam int DEPTH = 8;
   localparam int PW    = 16;
   localparam int AW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] probe = '0;
   logic          trig = 1'b0;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_addr = 2'd0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [AW-1:0] rd_idx = '0;
   logic [PW-1:0] rd_data;
   logic          rd_ok;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   lacap_top #(.DEPTH(DEPTH), .PROBE_W(PW), .HOLD_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .probe(probe), .trig(trig),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .rd_idx(rd_idx), .rd_data(rd_data), .rd_ok(rd_ok)
   );

   // probe is a free-running count, settled well before each negedge
   initial begin
      forever begin
         @(posedge clk);
         #3;
         probe = probe + 1'b1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic fire_trig(output int t);
      trig = 1'b1;
      t = int'(probe);
      @(negedge clk);
      trig = 1'b0;
   endtask

   task automatic wait_done(input string req);
      logic [31:0] s;
      int k = 0;
      rd_reg(2'd3, s);
      while (!s[3] && k < 200) begin
         @(negedge clk);
         rd_reg(2'd3, s);
         k++;
      end
      chk(req, int'(s[3]), 1);
   endtask

   task automatic read_pos(input int i, output int d, output int ok);
      rd_idx = AW'(i);
      @(negedge clk);
      d  = int'(rd_data);
      ok = int'(rd_ok);
   endtask

   // positions below first_ok must be unwritten; the rest hold base+i
   task automatic check_window(input string req, input int base, input int first_ok);
      int d, ok;
      for (int i = 0; i < DEPTH; i++) begin
         read_pos(i, d, ok);
         chk(req, ok, (i >= first_ok) ? 1 : 0);
         if (i >= first_ok) chk(req, d, (base + i) & 16'hFFFF);
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd_reg(2'd3, v);
      chk("R1 state", int'(v[2:0]), 0);
      chk("R1 done", int'(v[3]), 0);
      rd_reg(2'd0, v);
      chk("R1 mode", int'(v[1:0]), 0);
      rd_reg(2'd1, v);
      chk("R1 holdoff", int'($signed(v)), -DEPTH / 2);
   endtask

   task automatic t_single(input string req, input int h, input int pos);
      int t;
      logic [31:0] v;
      wr_reg(2'd1, 32'(h));
      wr_reg(2'd2, 32'd1);
      rd_reg(2'd3, v);
      chk("R2 armed", int'(v[2:0]), 1);
      repeat (20) @(negedge clk);
      fire_trig(t);
      if (h > 0) begin
         rd_reg(2'd3, v);
         chk("R4 hold state", int'(v[2:0]), 2);
      end
      wait_done("R7 done");
      rd_reg(2'd3, v);
      chk("R7 state done", int'(v[2:0]), 4);
      chk("R9 no gaps", int'(v[4]), 0);
      check_window(req, (h > 0) ? t + h : t - pos, 0);
   endtask

   task automatic t_early();
      int t;
      logic [31:0] v;
      wr_reg(2'd1, 32'(-4));
      wr_reg(2'd2, 32'd1);
      fire_trig(t);
      wait_done("R9 done");
      rd_reg(2'd3, v);
      chk("R9 gaps bit", int'(v[4]), 1);
      check_window("R9 early window", t - 4, 4);
   endtask

   task automatic t_incr();
      int ex[DEPTH];
      int n = 0;
      int j = 0;
      int d, ok;
      logic [31:0] v;
      wr_reg(2'd0, 32'd1);
      wr_reg(2'd2, 32'd1);
      while (n < DEPTH) begin
         if (n == 4 && (j % 3) == 0) begin
            rd_reg(2'd3, v);
            chk("R5 still armed", int'(v[2:0]), 1);
         end
         trig = ((j % 3) == 0);
         if (trig) begin
            ex[n] = int'(probe);
            n++;
         end
         @(negedge clk);
         j++;
      end
      trig = 1'b0;
      wait_done("R5 done");
      for (int i = 0; i < DEPTH; i++) begin
         read_pos(i, d, ok);
         chk("R5 incr sample", d, ex[i]);
         chk("R8 valid", ok, 1);
      end
   endtask

   task automatic t_imm();
      int a;
      wr_reg(2'd0, 32'd2);
      wr_reg(2'd2, 32'd1);
      a = int'(probe);
      wait_done("R6 done");
      check_window("R6 immediate", a, 0);
   endtask

   task automatic t_locked_and_done();
      int t, t2, d0, ok0, d1, ok1;
      logic [31:0] v;
      wr_reg(2'd0, 32'd0);
      wr_reg(2'd1, 32'(-4));
      wr_reg(2'd2, 32'd1);
      wr_reg(2'd0, 32'd1);
      wr_reg(2'd1, 32'd5);
      rd_reg(2'd0, v);
      chk("R10 mode kept", int'(v[1:0]), 0);
      rd_reg(2'd1, v);
      chk("R10 holdoff kept", int'($signed(v)), -4);
      repeat (10) @(negedge clk);
      fire_trig(t);
      wait_done("R10 done");
      check_window("R10 window", t - 4, 0);
      read_pos(0, d0, ok0);
      fire_trig(t2);
      repeat (12) @(negedge clk);
      rd_reg(2'd3, v);
      chk("R7 stays done", int'(v[2:0]), 4);
      read_pos(0, d1, ok1);
      chk("R7 data kept", d1, d0);
      wr_reg(2'd2, 32'd1);
      rd_reg(2'd3, v);
      chk("R2 rearm clears done", int'(v[3]), 0);
      chk("R2 rearm state", int'(v[2:0]), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single("R3 centred", -4, 4);
      t_single("R3 zero", 0, 0);
      t_single("R4 positive", 3, 0);
      t_single("R3 clamped", -8, 7);
      t_early();
      t_incr();
      t_imm();
      t_locked_and_done();
      finished = 1;
      summary();
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
      end
   end

endmodule